// File: doc/BRIEF.md
# Prefetch Queue Shadow Tracker

This block keeps a passive copy of a small processor's four-byte instruction prefetch queue, rebuilt only from what can be seen outside the processor. A bus cycle tracker upstream reports each captured data byte together with the type of the bus cycle it belongs to. On the same rising CPU clock edges, the block samples the processor's two queue status lines. Bytes from code fetches go into the shadow queue. The queue status reports then take bytes out, empty the queue, or mark where an instruction begins.

Each byte taken from the queue is appended to an instruction buffer. When the status lines report the first byte of a new instruction, the buffered bytes of the previous instruction are presented as one complete instruction, with a byte count and a one-cycle strobe. Pops from an empty queue and pushes into a full queue raise one-cycle error pulses, which flag a trace that is inconsistent or was sampled wrongly. The block never drives the processor or its bus.

Top module: `pfq_shadow`

## Requirements
- R1: The shadow queue holds at most four bytes. `q_level` reports how many bytes it holds and changes in the cycle after the clock edge that sampled the cause.
- R2: A byte is pushed only when `cap_valid` is high and `cyc_type` equals 3'b100 (code fetch). A valid byte with any other cycle type leaves the queue unchanged.
- R3: A push into a full queue with no pop in the same clock drops the byte, leaves the contents unchanged, and pulses `q_overflow` for one cycle.
- R4: Queue status 2'b10 (flush) empties the queue. It also discards the partly built instruction without emitting it, and drops a code byte captured in the same clock.
- R5: Queue status 2'b01 or 2'b11 on an empty queue pulses `q_underflow` for one cycle and appends nothing. A code byte captured in the same clock is still stored.
- R6: Queue status 2'b01 (first byte) closes the instruction being built, if it holds at least one byte. The next cycle then has `ins_done` high for one cycle, `ins_len` holding its byte count, and `ins_bytes` holding its bytes with the first byte in bits 7:0 and unused lanes zero. The byte popped by this status starts the new instruction.
- R7: Queue status 2'b11 (subsequent byte) pops the oldest byte and appends it to the instruction being built. Past six bytes, popped bytes are discarded and the count stays at six.
- R8: When a push and a pop fall in the same clock, the pop takes the oldest existing byte and the new byte goes to the tail. The level stays the same, even when the queue is full.
- R9: After reset the queue is empty, `ins_done`, `q_underflow` and `q_overflow` are low, `ins_len` is zero and `ins_bytes` is zero.
- R10: Queue status 2'b00 changes neither the queue contents nor the instruction being built, apart from pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Captured data byte is valid this clock |
| cap_data | input | 8 | Captured data byte |
| cyc_type | input | 3 | Bus cycle type from the cycle tracker; 3'b100 is a code fetch |
| qs | input | 2 | Queue status: 00 none, 01 first byte, 10 flush, 11 subsequent byte |
| q_level | output | 3 | Number of bytes in the shadow queue |
| q_underflow | output | 1 | One-cycle pulse: pop reported on an empty queue |
| q_overflow | output | 1 | One-cycle pulse: code byte arrived with the queue full and no pop |
| ins_done | output | 1 | One-cycle strobe: a complete instruction is presented |
| ins_len | output | 3 | Byte count of the presented instruction |
| ins_bytes | output | 48 | Bytes of the presented instruction, first byte in bits 7:0 |

## Verification
The assertions assume that every input is a known value at every sampled rising edge once reset is released, and that a change on the queue status lines lasts a single sampled clock. Any pairing of push, pop and flush in one clock is treated as legal, because a wrongly sampled trace must still yield well-defined flags rather than undefined state. The stimulus changes inputs only at falling edges and drives every input from time zero. It mixes directed sequences (fill to full, overflow, simultaneous push and pop at full, flush with a colliding fetch, an instruction longer than six bytes) with a long random run in which all status codes and cycle types occur.

// File: rtl/pfq_pkg.sv
// Shared encodings for the prefetch queue shadow tracker.
// Assumes queue status is sampled as {QS1,QS0} on the rising CPU clock.
package pfq_pkg;

    typedef enum logic [1:0] {
        QS_NOP    = 2'b00,
        QS_FIRST  = 2'b01,
        QS_FLUSH  = 2'b10,
        QS_SUBSEQ = 2'b11
    } qstat_e;

    localparam logic [2:0] CYC_CODE = 3'b100;

endpackage

// File: rtl/pfq_byte_queue.sv
// Shadow byte FIFO with push, pop and flush in one clock.
// Flush wins over both push and pop. A pop in the same clock as a push
// is taken from the existing contents, so a full queue accepts the push.
// Assumes DEPTH >= 2.
module pfq_byte_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic                         pop_ok,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         underflow,
    output logic                         overflow
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          empty, full, push_ok;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    // Decide which requested operations are honoured this clock.
    always_comb begin
        empty   = (level == '0);
        full    = (level == FULL_LVL);
        pop_ok  = pop && !flush && !empty;
        push_ok = push && !flush && (!full || pop_ok);
        head    = mem[rd_ptr];
    end

    // Pointer, occupancy and error-pulse state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            level     <= '0;
            underflow <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            underflow <= pop && !flush && empty;
            overflow  <= push && !flush && !push_ok;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= '0;
                level  <= '0;
            end else begin
                if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
                if (push_ok) wr_ptr <= ptr_next(wr_ptr);
                level <= level + LW'(push_ok) - LW'(pop_ok);
            end
        end
    end

    // Byte storage, written at the tail on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/pfq_insn_builder.sv
// Collects popped bytes into the instruction being built and presents it
// when the next first-byte report closes it. Holds up to MAXB bytes; extra
// bytes are dropped and the count saturates. Empty instructions are not
// presented. Unused output lanes are zero because the buffer is cleared
// whenever an instruction starts or is discarded.
module pfq_insn_builder #(
    parameter int MAXB = 6,
    parameter int W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        append_ok,
    input  logic                        discard,
    input  logic [W-1:0]                din,
    output logic                        done,
    output logic [$clog2(MAXB+1)-1:0]   out_len,
    output logic [MAXB*W-1:0]           out_bytes
);
    localparam int NW = $clog2(MAXB + 1);
    localparam logic [NW-1:0] MAX_LEN = NW'(MAXB);

    logic [W-1:0]  bufr [MAXB];
    logic [NW-1:0] len;

    // Assembly buffer and its fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
            for (int i = 0; i < MAXB; i++) bufr[i] <= '0;
        end else if (discard) begin
            len <= '0;
            for (int i = 0; i < MAXB; i++) bufr[i] <= '0;
        end else if (start) begin
            for (int i = 0; i < MAXB; i++) bufr[i] <= '0;
            if (append_ok) begin
                bufr[0] <= din;
                len     <= NW'(1);
            end else begin
                len <= '0;
            end
        end else if (append_ok && (len < MAX_LEN)) begin
            bufr[len] <= din;
            len       <= len + NW'(1);
        end
    end

    // Presentation of the closed instruction with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            out_len   <= '0;
            out_bytes <= '0;
        end else begin
            done <= 1'b0;
            if (start && !discard && (len != '0)) begin
                done    <= 1'b1;
                out_len <= len;
                for (int i = 0; i < MAXB; i++) out_bytes[i*W +: W] <= bufr[i];
            end
        end
    end

endmodule

// File: rtl/pfq_shadow.sv
// Passive shadow of a processor prefetch queue. Decodes the sampled queue
// status and the upstream cycle type into push/pop/flush requests for the
// byte queue, and routes popped bytes into the instruction builder.
// Assumes all inputs are synchronous to clk and sampled on its rising edge.
module pfq_shadow #(
    parameter int DEPTH = 4,
    parameter int MAXB  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_valid,
    input  logic [7:0]                   cap_data,
    input  logic [2:0]                   cyc_type,
    input  logic [1:0]                   qs,
    output logic [$clog2(DEPTH+1)-1:0]   q_level,
    output logic                         q_underflow,
    output logic                         q_overflow,
    output logic                         ins_done,
    output logic [$clog2(MAXB+1)-1:0]    ins_len,
    output logic [MAXB*8-1:0]            ins_bytes
);
    import pfq_pkg::*;

    qstat_e     qstat;
    logic       do_push, do_pop, do_flush, do_first;
    logic       pop_ok;
    logic [7:0] head;

    // Decode the status code and cycle type into queue requests.
    always_comb begin
        qstat    = qstat_e'(qs);
        do_push  = cap_valid && (cyc_type == CYC_CODE);
        do_flush = (qstat == QS_FLUSH);
        do_first = (qstat == QS_FIRST);
        do_pop   = (qstat == QS_FIRST) || (qstat == QS_SUBSEQ);
    end

    pfq_byte_queue #(
        .DEPTH (DEPTH),
        .W     (8)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .flush     (do_flush),
        .din       (cap_data),
        .head      (head),
        .pop_ok    (pop_ok),
        .level     (q_level),
        .underflow (q_underflow),
        .overflow  (q_overflow)
    );

    pfq_insn_builder #(
        .MAXB (MAXB),
        .W    (8)
    ) u_build (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (do_first),
        .append_ok (pop_ok),
        .discard   (do_flush),
        .din       (head),
        .done      (ins_done),
        .out_len   (ins_len),
        .out_bytes (ins_bytes)
    );

endmodule

// File: rtl/pfq_shadow_checker.sv
// Port-level properties of the prefetch queue shadow, bound to its top.
module pfq_shadow_checker #(
    parameter int DEPTH = 4,
    parameter int MAXB  = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cap_valid,
    input logic [2:0]                  cyc_type,
    input logic [1:0]                  qs,
    input logic [$clog2(DEPTH+1)-1:0]  q_level,
    input logic                        q_underflow,
    input logic                        q_overflow,
    input logic                        ins_done,
    input logic [$clog2(MAXB+1)-1:0]   ins_len
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(MAXB + 1);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LW'(DEPTH));

    p_non_code_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (qs == 2'b00 && !(cap_valid && cyc_type == 3'b100)) |=> $stable(q_level));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_overflow |-> ($past(q_level) == LW'(DEPTH) && $past(qs) == 2'b00));

    p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qs == 2'b10) |=> (q_level == '0 && !ins_done));

    p_underflow_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_underflow |-> ($past(q_level) == '0 && $past(qs[0])));

    p_done_after_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_done |-> ($past(qs) == 2'b01 && ins_len != '0));

    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_len <= NW'(MAXB));

    p_swap_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qs[0] && q_level != '0 && cap_valid && cyc_type == 3'b100) |=> $stable(q_level));

    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_underflow, q_overflow}));

endmodule

bind pfq_shadow pfq_shadow_checker #(.DEPTH(DEPTH), .MAXB(MAXB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid   (cap_valid),
    .cyc_type    (cyc_type),
    .qs          (qs),
    .q_level     (q_level),
    .q_underflow (q_underflow),
    .q_overflow  (q_overflow),
    .ins_done    (ins_done),
    .ins_len     (ins_len)
);

// File: tb/tb_pfq_shadow.sv
module tb_pfq_shadow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [7:0]  cap_data = 8'h00;
    logic [2:0]  cyc_type = 3'b000;
    logic [1:0]  qs = 2'b00;
    logic [2:0]  q_level;
    logic        q_underflow, q_overflow, ins_done;
    logic [2:0]  ins_len;
    logic [47:0] ins_bytes;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0]  mq[$];
    logic [7:0]  aq[$];
    logic        e_done, e_uf, e_of;
    logic [2:0]  e_len;
    logic [47:0] e_bytes;

    always #10 clk = ~clk;   // 50 MHz

    pfq_shadow dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
        .cyc_type(cyc_type), .qs(qs), .q_level(q_level), .q_underflow(q_underflow),
        .q_overflow(q_overflow), .ins_done(ins_done), .ins_len(ins_len),
        .ins_bytes(ins_bytes)
    );

    task automatic check(input bit ok, input string tag, input logic [47:0] act,
                         input logic [47:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of one sampled clock edge.
    task automatic model_edge();
        logic push, popped;
        logic [7:0] b;
        push   = cap_valid && (cyc_type == 3'b100);
        e_done = 1'b0; e_uf = 1'b0; e_of = 1'b0;
        if (qs == 2'b10) begin
            mq.delete();
            aq.delete();
        end else begin
            popped = 1'b0;
            b = 8'h00;
            if (qs[0]) begin
                if (mq.size() == 0) e_uf = 1'b1;
                else begin b = mq.pop_front(); popped = 1'b1; end
            end
            if (qs == 2'b01) begin
                if (aq.size() > 0) begin
                    e_done  = 1'b1;
                    e_len   = 3'(aq.size());
                    e_bytes = '0;
                    foreach (aq[i]) e_bytes[i*8 +: 8] = aq[i];
                end
                aq.delete();
                if (popped) aq.push_back(b);
            end else if (qs == 2'b11 && popped && aq.size() < 6) begin
                aq.push_back(b);
            end
            if (push) begin
                if (mq.size() < 4) mq.push_back(cap_data);
                else e_of = 1'b1;
            end
        end
    endtask

    task automatic compare(input string ctx);
        check(q_level == 3'(mq.size()), {ctx, " R1 R2 R3 R8 R10 level"},
              48'(q_level), 48'(mq.size()));
        check(q_underflow == e_uf, {ctx, " R5 underflow"}, 48'(q_underflow), 48'(e_uf));
        check(q_overflow == e_of, {ctx, " R3 overflow"}, 48'(q_overflow), 48'(e_of));
        check(ins_done == e_done, {ctx, " R4 R6 done"}, 48'(ins_done), 48'(e_done));
        if (e_done) begin
            check(ins_len == e_len, {ctx, " R6 R7 length"}, 48'(ins_len), 48'(e_len));
            check(ins_bytes == e_bytes, {ctx, " R6 R7 bytes"}, ins_bytes, e_bytes);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] d, input logic [2:0] ct,
                        input logic [1:0] s, input string ctx);
        cap_valid = v; cap_data = d; cyc_type = ct; qs = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        e_done = 0; e_uf = 0; e_of = 0; e_len = 0; e_bytes = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(q_level == 0 && !ins_done && !q_underflow && !q_overflow,
              "R9 reset flags", {q_level, ins_done, q_underflow, q_overflow},
              48'h0);
        check(ins_len == 0 && ins_bytes == 0, "R9 reset output", ins_bytes, 48'h0);

        // R1 R3: fill to four, fifth code byte overflows
        for (int i = 0; i < 5; i++) step(1, 8'hA0 + 8'(i), 3'b100, 2'b00, "fill");
        // R2: valid data on a non-code cycle is ignored
        step(1, 8'h55, 3'b101, 2'b00, "noncode");
        // R8: push and pop at full keeps level
        step(1, 8'hB0, 3'b100, 2'b01, "swap first");
        step(1, 8'hB1, 3'b100, 2'b11, "swap sub");
        step(0, 8'h00, 3'b000, 2'b11, "sub");
        // R6: close two-to-three byte instruction
        step(0, 8'h00, 3'b000, 2'b01, "close");
        step(0, 8'h00, 3'b000, 2'b00, "idle R10");
        // R4: flush with a colliding fetch and a partial instruction
        step(0, 8'h00, 3'b000, 2'b11, "partial");
        step(1, 8'hC0, 3'b100, 2'b10, "flush");
        // R5: pop from empty with a same-clock push
        step(1, 8'hC1, 3'b100, 2'b11, "uf push");
        step(0, 8'h00, 3'b000, 2'b01, "uf first");
        step(0, 8'h00, 3'b000, 2'b01, "empty first");
        // R7: eight-byte instruction saturates at six
        for (int i = 0; i < 8; i++) begin
            step(1, 8'hD0 + 8'(i), 3'b100, (i == 0) ? 2'b01 : 2'b11, "long");
        end
        step(0, 8'h00, 3'b000, 2'b11, "long tail");
        step(0, 8'h00, 3'b000, 2'b01, "long close");

        // Random mix of every status code and cycle type
        for (int n = 0; n < 6000; n++) begin
            logic [1:0] s;
            int r;
            r = $urandom_range(0, 99);
            s = (r < 40) ? 2'b00 : (r < 60) ? 2'b01 : (r < 95) ? 2'b11 : 2'b10;
            step(($urandom_range(0, 99) < 55), 8'($urandom()),
                 ($urandom_range(0, 3) == 0) ? 3'($urandom()) : 3'b100, s, "rand");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule